// File: doc/BRIEF.md
# Sector Group Write Protection Unit

This unit guards a byte-wide flash array of sixteen 64 KB sectors against unwanted program and erase operations. Protection is held per group, and each group covers two adjacent sectors, so the eight groups are selected by the top three bits of the 20-bit byte address. Each request (program or erase) gets one registered verdict: a grant pulse or a deny pulse in the cycle after the request.

A temporary-unprotect input lifts every lock while it is held. Protection bits are set or cleared by a command port that stands in for the external high-voltage procedure. Set and clear commands are ignored while the override is active. For this reason, when the override drops, every group that was locked before it began is locked again. An identification-read port returns 01h for any sector whose group is locked and 00h otherwise.

Top module: `sgrp_guard`

## Requirements
- R1: After reset every group is unprotected, `query_code` is 00h for every address, and `grant` and `deny` are low.
- R2: The group of an address is bits 19..17. Both sectors of a group (bit 16 = 0 or 1) share one protection state, and bits 15..0 have no effect.
- R3: A request (`req_op` 0 = program, 1 = erase) to a locked group while `tmp_unlock` is low gives `deny` high and `grant` low in the cycle after the request.
- R4: A request to an unlocked group gives `grant` high and `deny` low in the cycle after the request.
- R5: `grant` and `deny` are never high together. Each is high only in the cycle after a cycle with `req_valid` high, so one request cycle gives a one-cycle pulse.
- R6: While `tmp_unlock` is high, every request is granted, whatever the stored protection.
- R7: After `tmp_unlock` falls, every group that was locked before it rose again denies requests.
- R8: `query_code` (combinational on `query_addr`) is 01h when the group of `query_addr` holds a set protection bit and 00h otherwise. It reports the stored bit even while `tmp_unlock` is high.
- R9: Protection commands presented while `tmp_unlock` is high have no effect on any group.
- R10: A denied request leaves every protection bit unchanged.
- R11: A command with `prot_cmd_set` = 1 locks, and with 0 unlocks, only the group in bits 19..17 of `prot_cmd_addr`. The change is visible on `query_code` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program/erase request strobe |
| req_op | input | 1 | 0 = program, 1 = erase |
| req_addr | input | 20 | Byte address of the request |
| tmp_unlock | input | 1 | Temporary global unprotect override |
| prot_cmd_valid | input | 1 | Protection command strobe |
| prot_cmd_set | input | 1 | 1 = lock group, 0 = unlock group |
| prot_cmd_addr | input | 20 | Address selecting the group to change |
| query_addr | input | 20 | Address for identification read |
| grant | output | 1 | Request accepted (one-cycle pulse) |
| deny | output | 1 | Request rejected (one-cycle pulse) |
| query_code | output | 8 | 01h locked, 00h unlocked |

## Verification
The assertions assume that `tmp_unlock` changes only between clock edges and that `req_valid` is low for the whole reset interval. They also assume that a request in the cycle of a protection command is judged against the bits held before that command. The bench drives every input on the falling edge and holds `req_valid` low during reset. It sweeps all sixteen sectors and both operation types under several lock patterns, with and without the override. It also tries to issue commands while the override is active, and compares every verdict and query against a group mask it computes itself.

// File: rtl/sgrp_pkg.sv
package sgrp_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } flash_op_e;

  localparam int unsigned ID_CODE_W = 8;
endpackage

// File: rtl/sgrp_store.sv
module sgrp_store #(
  parameter int unsigned GRP_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic                    cmd_set,
  input  logic [GRP_W-1:0]        cmd_grp,
  input  logic                    freeze,
  output logic [(1<<GRP_W)-1:0]   prot_q
);
  localparam int unsigned NUM_GRP = 1 << GRP_W;

  logic [NUM_GRP-1:0] load_en;
  logic [NUM_GRP-1:0] prot_d;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bit
    always_comb begin
      load_en[g] = cmd_valid && !freeze && (cmd_grp == GRP_W'(g));
      prot_d[g]  = load_en[g] ? cmd_set : prot_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prot_q[g] <= 1'b0;
      else if (load_en[g]) prot_q[g] <= prot_d[g];
    end
  end

  // R9: the override freezes the stored bits
  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(prot_q));

  // R11: at most one group changes per cycle
  assert_one_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(prot_q ^ $past(prot_q)) <= 1);
endmodule

// File: rtl/sgrp_decide.sv
module sgrp_decide (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic tmp_unlock,
  input  logic grp_locked,
  output logic grant,
  output logic deny
);
  logic grant_d;
  logic deny_d;

  always_comb begin
    grant_d = req_valid && (tmp_unlock || !grp_locked);
    deny_d  = req_valid && !tmp_unlock && grp_locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= grant_d;
      deny  <= deny_d;
    end
  end

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));

  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant || deny) |-> $past(req_valid));

  assert_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tmp_unlock) |=> grant);

  assert_locked_deny_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tmp_unlock && grp_locked) |=> (deny && !grant));
endmodule

// File: rtl/sgrp_query.sv
module sgrp_query #(
  parameter int unsigned GRP_W  = 3,
  parameter int unsigned CODE_W = 8
) (
  input  logic [(1<<GRP_W)-1:0] prot_q,
  input  logic [GRP_W-1:0]      query_grp,
  output logic [CODE_W-1:0]     query_code
);
  always_comb begin
    query_code    = '0;
    query_code[0] = prot_q[query_grp];
  end
endmodule

// File: rtl/sgrp_guard.sv
module sgrp_guard
  import sgrp_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned GRP_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 tmp_unlock,
  input  logic                 prot_cmd_valid,
  input  logic                 prot_cmd_set,
  input  logic [ADDR_W-1:0]    prot_cmd_addr,
  input  logic [ADDR_W-1:0]    query_addr,
  output logic                 grant,
  output logic                 deny,
  output logic [ID_CODE_W-1:0] query_code
);
  localparam int unsigned NUM_GRP = 1 << GRP_W;
  localparam int unsigned LOW_W   = ADDR_W - GRP_W;

  logic [GRP_W-1:0]   req_grp;
  logic [GRP_W-1:0]   cmd_grp;
  logic [GRP_W-1:0]   qry_grp;
  logic [NUM_GRP-1:0] prot_q;
  logic               grp_locked;
  logic               unused_bits;

  always_comb begin
    req_grp    = req_addr[ADDR_W-1 -: GRP_W];
    cmd_grp    = prot_cmd_addr[ADDR_W-1 -: GRP_W];
    qry_grp    = query_addr[ADDR_W-1 -: GRP_W];
    grp_locked = prot_q[req_grp];
  end

  // both operation types share one rule; offsets inside a group do not matter
  assign unused_bits = ^{req_op, req_addr[LOW_W-1:0],
                         prot_cmd_addr[LOW_W-1:0], query_addr[LOW_W-1:0]};

  sgrp_store #(.GRP_W(GRP_W)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (prot_cmd_valid),
    .cmd_set   (prot_cmd_set),
    .cmd_grp   (cmd_grp),
    .freeze    (tmp_unlock),
    .prot_q    (prot_q)
  );

  sgrp_decide decide_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .tmp_unlock (tmp_unlock),
    .grp_locked (grp_locked),
    .grant      (grant),
    .deny       (deny)
  );

  sgrp_query #(.GRP_W(GRP_W), .CODE_W(ID_CODE_W)) query_i (
    .prot_q     (prot_q),
    .query_grp  (qry_grp),
    .query_code (query_code)
  );

  // R10: a denied verdict coincides with no protection change
  assert_deny_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tmp_unlock && grp_locked && !prot_cmd_valid) |=> $stable(prot_q));

  // R4: unlocked group without override is granted
  assert_open_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !grp_locked) |=> (grant && !deny));
endmodule

// File: tb/sgrp_guard_tb.sv
module sgrp_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int N_SECT     = 16;
  localparam int N_GRP      = 8;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_op;
  logic [ADDR_W-1:0] req_addr;
  logic              tmp_unlock;
  logic              prot_cmd_valid;
  logic              prot_cmd_set;
  logic [ADDR_W-1:0] prot_cmd_addr;
  logic [ADDR_W-1:0] query_addr;
  logic              grant;
  logic              deny;
  logic [7:0]        query_code;

  int n_checks = 0;
  int n_errors = 0;
  logic [N_GRP-1:0] model;

  sgrp_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .tmp_unlock(tmp_unlock),
    .prot_cmd_valid(prot_cmd_valid), .prot_cmd_set(prot_cmd_set),
    .prot_cmd_addr(prot_cmd_addr), .query_addr(query_addr),
    .grant(grant), .deny(deny), .query_code(query_code)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] sect_addr(input int s, input int salt);
    return {s[3:0], 16'((s * 4099 + salt * 257) & 16'hFFFF)};
  endfunction

  task automatic do_cmd(input bit set, input int g, input int salt);
    @(negedge clk);
    prot_cmd_valid = 1'b1;
    prot_cmd_set   = set;
    prot_cmd_addr  = {g[2:0], 17'((salt * 7919) & 17'h1FFFF)};
    @(negedge clk);
    prot_cmd_valid = 1'b0;
    if (!tmp_unlock) model[g] = set;
  endtask

  task automatic q_check(input int s, input int salt, input string tag);
    logic [7:0] exp;
    exp = {7'd0, model[s/2]};
    query_addr = sect_addr(s, salt);
    #1;
    check(query_code == exp, tag, query_code, exp);
  endtask

  task automatic q_all(input string tag);
    for (int s = 0; s < N_SECT; s++) q_check(s, s + 3, tag);
  endtask

  task automatic do_req(input int s, input bit op, input string tag);
    bit exp_g;
    exp_g = tmp_unlock || !model[s/2];
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = sect_addr(s, op ? 11 : 5);
    @(negedge clk);
    req_valid = 1'b0;
    check(grant == exp_g && deny == !exp_g, tag, {grant, deny}, {exp_g, !exp_g});
    @(negedge clk);
    check(!grant && !deny, "R5 single-cycle pulse", {grant, deny}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [N_GRP-1:0] pats [5];
    logic [N_GRP-1:0] saved;
    pats = '{8'hA5, 8'h3C, 8'hFF, 8'h01, 8'h80};
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_addr = '0;
    tmp_unlock = 1'b0; prot_cmd_valid = 1'b0; prot_cmd_set = 1'b0;
    prot_cmd_addr = '0; query_addr = '0; model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!grant && !deny, "R1 outputs after reset", {grant, deny}, 0);
    q_all("R1 query after reset");
    for (int s = 0; s < N_SECT; s++) do_req(s, s[0], "R4 open after reset");

    foreach (pats[i]) begin
      for (int g = 0; g < N_GRP; g++) begin
        do_cmd(pats[i][g], g, i + g);
        q_all("R11 only target group changes");
      end
      q_all("R2 R8 sector pair shares group code");
      for (int s = 0; s < N_SECT; s++)
        for (int op = 0; op < 2; op++)
          do_req(s, op[0], model[s/2] ? "R3 locked group denied" : "R4 open group granted");
      q_all("R10 denials leave state");

      saved = model;
      @(negedge clk);
      tmp_unlock = 1'b1;
      for (int g = 0; g < N_GRP; g++) do_cmd(!saved[g], g, g);
      q_all("R9 commands ignored under override");
      q_all("R8 query shows stored bit under override");
      for (int s = 0; s < N_SECT; s++) do_req(s, s[1], "R6 override grants");
      @(negedge clk);
      tmp_unlock = 1'b0;
      check(model == saved, "R7 mask restored", model, saved);
      for (int s = 0; s < N_SECT; s++) do_req(s, s[0], "R7 relocked after override");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule